// File: doc/BRIEF.md
# Intra-Cycle VPN Compactor

This unit sits between four address-generation lanes and a small data translation array. Each cycle up to four lanes present a 32-bit virtual address. The unit compares the page numbers of every pair of valid lanes and picks one leader for each distinct page. Only leaders search the 32-entry fully-associative array. Each follower receives the leader's frame number and hit status. Lanes that land on one page therefore cost a single search. For example, 0xdeadbeee, 0xdeadbeef and 0xdeadbef0 in the same cycle collapse into one search of page 0xdeadb.

Responses are registered and appear one clock after the request. A lookup-count output reports how many array searches that cycle actually performed.

When a leader misses, a two-state controller raises a refill request carrying that page number. The request holds until an external walker writes a translation back through the refill port.
- **States:** `ST_IDLE` (no request outstanding) and `ST_WAIT` (request raised and held).
- **Transitions:** `ST_IDLE` moves to `ST_WAIT` on any leader miss. `ST_WAIT` returns to `ST_IDLE` on a refill write.
- **Replacement:** a refill write takes the round-robin victim slot. If the page is already resident, the write updates that entry in place instead.

Top module: `tlbc_compactor`

## Requirements
- R1: After reset `rsp_valid`, `rsp_hit`, `lookup_cnt` and `refill_req_valid` are zero, and every array entry is empty, so the first search misses.
- R2: `rsp_valid[k]` in a cycle equals `req_valid[k]` of the previous cycle; hit status and frame number return with it, one cycle after the request.
- R3: The page number is address bits [31:12]; `lookup_cnt` equals the number of distinct page numbers among valid lanes in the previous cycle (0 to 4).
- R4: Every valid lane whose page equals that of a lower valid lane reports the same `rsp_hit` and `rsp_pfn` as the lowest such lane.
- R5: An invalid lane takes part in no match, adds nothing to `lookup_cnt`, and reports `rsp_hit` 0 and `rsp_pfn` 0.
- R6: A hit returns the frame number most recently written for that page; a missing lane reports `rsp_pfn` 0.
- R7: When a leader misses in `ST_IDLE`, `refill_req_valid` is 1 in the next cycle with `refill_req_vpn` equal to the lowest-numbered missing leader's page. The request and its page stay unchanged until the cycle after a refill write.
- R8: A refill write of a non-resident page fills slots in round-robin order starting at slot 0 after reset, so the 33rd distinct page evicts the first.
- R9: A refill write of a page already resident overwrites that entry's frame number and does not advance the round-robin pointer.
- R10: A refill write becomes visible to searches from the next cycle; a search in the same cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 4 | Per-lane request valid |
| req_vaddr | input | 4x32 | Per-lane virtual address |
| rsp_valid | output | 4 | Per-lane response valid |
| rsp_hit | output | 4 | Per-lane translation hit |
| rsp_pfn | output | 4x20 | Per-lane frame number, 0 on miss |
| lookup_cnt | output | 3 | Array searches performed for this response |
| refill_req_valid | output | 1 | Refill request outstanding |
| refill_req_vpn | output | 20 | Page number to be fetched |
| refill_valid | input | 1 | Refill write strobe |
| refill_vpn | input | 20 | Page number being written |
| refill_pfn | input | 20 | Frame number being written |

## Verification
The assertions assume that reset is held low for at least one clock edge before any request. They also assume that a refill write is a single-cycle strobe with stable page and frame values. The bench keeps to both assumptions. Its tasks drive all inputs only at the falling edge, and each refill is raised for exactly one cycle. Patterns mix shared pages, invalid lanes carrying matching addresses, all-distinct pages and misses. The refill-hold property is then exercised, including a new miss that arrives while a request is already outstanding.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } fill_state_e;
endpackage

// File: rtl/tlbc_match.sv
module tlbc_match #(
    parameter int LANES = 4,
    parameter int VPN_W = 20,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0]            vld,
    input  logic [LANES-1:0][VPN_W-1:0] vpn,
    output logic [LANES-1:0]            lead,
    output logic [LANES-1:0][IDX_W-1:0] lead_idx
);
    // same[i][j] set when lower lane i and higher lane j share a valid page
    logic [LANES-1:0][LANES-1:0] same;

    for (genvar i = 0; i < LANES; i++) begin : g_row
        for (genvar j = 0; j < LANES; j++) begin : g_col
            if (i < j) begin : g_cmp
                assign same[i][j] = vld[i] && vld[j] && (vpn[i] == vpn[j]);
            end else begin : g_none
                assign same[i][j] = 1'b0;
            end
        end
    end

    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            lead[j]     = vld[j];
            lead_idx[j] = IDX_W'(j);
            for (int i = LANES - 1; i >= 0; i--) begin
                if (i < j && same[i][j]) begin
                    lead[j]     = 1'b0;
                    lead_idx[j] = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/tlbc_array.sv
module tlbc_array #(
    parameter int LANES   = 4,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ENTRIES = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            srch_en,
    input  logic [LANES-1:0][VPN_W-1:0] srch_vpn,
    output logic [LANES-1:0]            srch_hit,
    output logic [LANES-1:0][PFN_W-1:0] srch_pfn,
    input  logic                        wr_en,
    input  logic [VPN_W-1:0]            wr_vpn,
    input  logic [PFN_W-1:0]            wr_pfn
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]            ent_vld;
    logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
    logic [ENTRIES-1:0][PFN_W-1:0] ent_pfn;
    logic [PTR_W-1:0]              rr_ptr;

    for (genvar g = 0; g < LANES; g++) begin : g_port
        logic             p_hit;
        logic [PFN_W-1:0] p_pfn;
        always_comb begin
            p_hit = 1'b0;
            p_pfn = '0;
            for (int e = 0; e < ENTRIES; e++) begin
                if (srch_en[g] && ent_vld[e] && ent_vpn[e] == srch_vpn[g]) begin
                    p_hit = 1'b1;
                    p_pfn = p_pfn | ent_pfn[e];
                end
            end
        end
        assign srch_hit[g] = p_hit;
        assign srch_pfn[g] = p_pfn;
    end

    // resident check for the write port keeps entries unique
    logic             dup_hit;
    logic [PTR_W-1:0] dup_idx;
    logic [PTR_W-1:0] wr_idx;

    always_comb begin
        dup_hit = 1'b0;
        dup_idx = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (ent_vld[e] && ent_vpn[e] == wr_vpn) begin
                dup_hit = 1'b1;
                dup_idx = PTR_W'(e);
            end
        end
        wr_idx = dup_hit ? dup_idx : rr_ptr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
            ent_vpn <= '0;
            ent_pfn <= '0;
            rr_ptr  <= '0;
        end else if (wr_en) begin
            ent_vld[wr_idx] <= 1'b1;
            ent_vpn[wr_idx] <= wr_vpn;
            ent_pfn[wr_idx] <= wr_pfn;
            if (!dup_hit) begin
                rr_ptr <= (rr_ptr == PTR_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlbc_fanout.sv
module tlbc_fanout #(
    parameter int LANES = 4,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0]            vld,
    input  logic [LANES-1:0]            lead,
    input  logic [LANES-1:0][IDX_W-1:0] lead_idx,
    input  logic [LANES-1:0][VPN_W-1:0] vpn,
    input  logic [LANES-1:0]            arr_hit,
    input  logic [LANES-1:0][PFN_W-1:0] arr_pfn,
    output logic [LANES-1:0]            lane_hit,
    output logic [LANES-1:0][PFN_W-1:0] lane_pfn,
    output logic                        miss_any,
    output logic [VPN_W-1:0]            miss_vpn
);
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            lane_hit[j] = vld[j] && arr_hit[lead_idx[j]];
            lane_pfn[j] = lane_hit[j] ? arr_pfn[lead_idx[j]] : '0;
        end
        miss_any = 1'b0;
        miss_vpn = '0;
        for (int j = LANES - 1; j >= 0; j--) begin
            if (lead[j] && !arr_hit[j]) begin
                miss_any = 1'b1;
                miss_vpn = vpn[j];
            end
        end
    end
endmodule

// File: rtl/tlbc_compactor.sv
module tlbc_compactor
    import tlbc_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int VA_W    = 32,
    parameter int OFS_W   = 12,
    parameter int PFN_W   = 20,
    parameter int ENTRIES = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [LANES-1:0]                    req_valid,
    input  logic [LANES-1:0][VA_W-1:0]          req_vaddr,
    output logic [LANES-1:0]                    rsp_valid,
    output logic [LANES-1:0]                    rsp_hit,
    output logic [LANES-1:0][PFN_W-1:0]         rsp_pfn,
    output logic [$clog2(LANES+1)-1:0]          lookup_cnt,
    output logic                                refill_req_valid,
    output logic [VA_W-OFS_W-1:0]               refill_req_vpn,
    input  logic                                refill_valid,
    input  logic [VA_W-OFS_W-1:0]               refill_vpn,
    input  logic [PFN_W-1:0]                    refill_pfn
);
    localparam int VPN_W = VA_W - OFS_W;
    localparam int CNT_W = $clog2(LANES + 1);
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LANES-1:0][VPN_W-1:0] lane_vpn;
    for (genvar k = 0; k < LANES; k++) begin : g_vpn
        assign lane_vpn[k] = req_vaddr[k][VA_W-1:OFS_W];
    end

    logic [LANES-1:0]            lead;
    logic [LANES-1:0][IDX_W-1:0] lead_idx;
    logic [LANES-1:0]            arr_hit;
    logic [LANES-1:0][PFN_W-1:0] arr_pfn;
    logic [LANES-1:0]            lane_hit;
    logic [LANES-1:0][PFN_W-1:0] lane_pfn;
    logic                        miss_any;
    logic [VPN_W-1:0]            miss_vpn;

    tlbc_match #(.LANES(LANES), .VPN_W(VPN_W)) u_match (
        .vld      (req_valid),
        .vpn      (lane_vpn),
        .lead     (lead),
        .lead_idx (lead_idx)
    );

    tlbc_array #(.LANES(LANES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ENTRIES(ENTRIES)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .srch_en  (lead),
        .srch_vpn (lane_vpn),
        .srch_hit (arr_hit),
        .srch_pfn (arr_pfn),
        .wr_en    (refill_valid),
        .wr_vpn   (refill_vpn),
        .wr_pfn   (refill_pfn)
    );

    tlbc_fanout #(.LANES(LANES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_fanout (
        .vld      (req_valid),
        .lead     (lead),
        .lead_idx (lead_idx),
        .vpn      (lane_vpn),
        .arr_hit  (arr_hit),
        .arr_pfn  (arr_pfn),
        .lane_hit (lane_hit),
        .lane_pfn (lane_pfn),
        .miss_any (miss_any),
        .miss_vpn (miss_vpn)
    );

    fill_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (miss_any)     state_nx = ST_WAIT;
            ST_WAIT: if (refill_valid) state_nx = ST_IDLE;
            default:                   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= '0;
            rsp_hit        <= '0;
            rsp_pfn        <= '0;
            lookup_cnt     <= '0;
            refill_req_vpn <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_hit    <= lane_hit;
            rsp_pfn    <= lane_pfn;
            lookup_cnt <= CNT_W'($countones(lead));
            if (state == ST_IDLE && miss_any) refill_req_vpn <= miss_vpn;
        end
    end

    assign refill_req_valid = (state == ST_WAIT);
endmodule

// File: rtl/tlbc_compactor_chk.sv
module tlbc_compactor_chk #(
    parameter int LANES = 4,
    parameter int VA_W  = 32,
    parameter int OFS_W = 12,
    parameter int PFN_W = 20
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [LANES-1:0]            req_valid,
    input logic [LANES-1:0][VA_W-1:0]  req_vaddr,
    input logic [LANES-1:0]            rsp_valid,
    input logic [LANES-1:0]            rsp_hit,
    input logic [LANES-1:0][PFN_W-1:0] rsp_pfn,
    input logic [$clog2(LANES+1)-1:0]  lookup_cnt,
    input logic                        refill_req_valid,
    input logic [VA_W-OFS_W-1:0]       refill_req_vpn,
    input logic                        refill_valid
);
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rsp_valid == $past(req_valid));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(lookup_cnt) <= $countones(rsp_valid));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit & ~rsp_valid) == '0);

    for (genvar i = 0; i < LANES; i++) begin : g_pi
        p_lane_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !rsp_valid[i] |-> rsp_pfn[i] == '0);
        for (genvar j = i + 1; j < LANES; j++) begin : g_pj
            p_shared_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid[i] && req_valid[j] &&
                 req_vaddr[i][VA_W-1:OFS_W] == req_vaddr[j][VA_W-1:OFS_W])
                |=> (rsp_hit[i] == rsp_hit[j] && rsp_pfn[i] == rsp_pfn[j]));
        end
    end

    p_refill_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req_valid && !refill_valid) |=> (refill_req_valid && $stable(refill_req_vpn)));

    p_refill_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req_valid && refill_valid) |=> !refill_req_valid);
endmodule

bind tlbc_compactor tlbc_compactor_chk #(
    .LANES(LANES), .VA_W(VA_W), .OFS_W(OFS_W), .PFN_W(PFN_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_vaddr        (req_vaddr),
    .rsp_valid        (rsp_valid),
    .rsp_hit          (rsp_hit),
    .rsp_pfn          (rsp_pfn),
    .lookup_cnt       (lookup_cnt),
    .refill_req_valid (refill_req_valid),
    .refill_req_vpn   (refill_req_vpn),
    .refill_valid     (refill_valid)
);

// File: tb/tlbc_compactor_tb.sv
`timescale 1ns/100ps
module tlbc_compactor_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        req_valid = '0;
    logic [3:0][31:0]  req_vaddr = '0;
    logic [3:0]        rsp_valid;
    logic [3:0]        rsp_hit;
    logic [3:0][19:0]  rsp_pfn;
    logic [2:0]        lookup_cnt;
    logic              refill_req_valid;
    logic [19:0]       refill_req_vpn;
    logic              refill_valid = 1'b0;
    logic [19:0]       refill_vpn = '0;
    logic [19:0]       refill_pfn = '0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [3:0][31:0] drv_va;

    always #2.5 clk = ~clk;

    tlbc_compactor u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn),
        .lookup_cnt(lookup_cnt), .refill_req_valid(refill_req_valid),
        .refill_req_vpn(refill_req_vpn), .refill_valid(refill_valid),
        .refill_vpn(refill_vpn), .refill_pfn(refill_pfn)
    );

    // valid[4] | lane0..lane3 addr | expected hit[4] | expected count[3]
    localparam int VW = 139;
    localparam logic [VW-1:0] VEC [7] = '{
        {4'b1111, 32'hdeadbeee, 32'hdeadbeef, 32'hdeadbef0, 32'hdeadbef2, 4'b1111, 3'd1},
        {4'b1111, 32'hdeadbeef, 32'h12345678, 32'hffffffff, 32'h00001000, 4'b1011, 3'd4},
        {4'b0101, 32'hdeadb000, 32'hdeadb111, 32'h12345000, 32'h12345fff, 4'b0101, 3'd2},
        {4'b0000, 32'hdeadb000, 32'hdeadb000, 32'h12345000, 32'h12345000, 4'b0000, 3'd0},
        {4'b1110, 32'hdeadb000, 32'h7ffff000, 32'h7ffff001, 32'h00001abc, 4'b1110, 3'd2},
        {4'b1111, 32'h00001000, 32'h12345000, 32'h7ffff000, 32'hdeadb000, 4'b1111, 3'd4},
        {4'b1010, 32'h00000000, 32'hfffff000, 32'h00000000, 32'hfffff004, 4'b0000, 3'd1}
    };

    function automatic logic [19:0] pfn_of(input logic [19:0] vpn);
        return vpn ^ 20'h5a5a5;
    endfunction

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_rsp(input string tag, input logic [3:0] ev, input logic [3:0] eh,
                             input logic [2:0] ec);
        check_val({tag, " valid"}, 32'(rsp_valid), 32'(ev));
        check_val({tag, " hit"}, 32'(rsp_hit), 32'(eh));
        check_val({tag, " count"}, 32'(lookup_cnt), 32'(ec));
        for (int k = 0; k < 4; k++) begin
            check_val($sformatf("%s pfn lane%0d", tag, k), 32'(rsp_pfn[k]),
                      eh[k] ? 32'(pfn_of(drv_va[k][31:12])) : 32'h0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = '0;
        refill_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_lookup(input logic [3:0] v, input logic [31:0] a0, input logic [31:0] a1,
                             input logic [31:0] a2, input logic [31:0] a3);
        @(negedge clk);
        req_valid = v;
        req_vaddr = {a3, a2, a1, a0};
        drv_va = {a3, a2, a1, a0};
        @(negedge clk);
        req_valid = '0;
    endtask

    task automatic do_refill(input logic [19:0] vpn, input logic [19:0] pfn);
        @(negedge clk);
        refill_valid = 1'b1;
        refill_vpn = vpn;
        refill_pfn = pfn;
        @(negedge clk);
        refill_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check_val("R1 rsp_valid", 32'(rsp_valid), 0);
        check_val("R1 lookup_cnt", 32'(lookup_cnt), 0);
        check_val("R1 refill_req_valid", 32'(refill_req_valid), 0);

        // R1 empty array, R7 request raised
        do_lookup(4'b0001, 32'h12345000, 0, 0, 0);
        check_rsp("R1 empty miss", 4'b0001, 4'b0000, 3'd1);
        check_val("R7 req raised", 32'(refill_req_valid), 1);
        check_val("R7 req vpn", 32'(refill_req_vpn), 32'h12345);

        // R7 held while a new miss arrives
        do_lookup(4'b0001, 32'h99999000, 0, 0, 0);
        check_val("R7 req held", 32'(refill_req_valid), 1);
        check_val("R7 vpn held", 32'(refill_req_vpn), 32'h12345);

        // R10 search in the refill cycle sees the old contents
        @(negedge clk);
        req_valid = 4'b0001;
        req_vaddr = {32'h0, 32'h0, 32'h0, 32'h12345000};
        drv_va = req_vaddr;
        refill_valid = 1'b1;
        refill_vpn = 20'h12345;
        refill_pfn = pfn_of(20'h12345);
        @(negedge clk);
        req_valid = '0;
        refill_valid = 1'b0;
        check_val("R10 same-cycle miss", 32'(rsp_hit), 0);
        check_val("R7 req dropped", 32'(refill_req_valid), 0);
        do_lookup(4'b0001, 32'h12345abc, 0, 0, 0);
        check_rsp("R10 R6 next-cycle hit", 4'b0001, 4'b0001, 3'd1);

        // R7 lowest missing leader chosen
        do_lookup(4'b0111, 32'h12345000, 32'h22222000, 32'h33333000, 0);
        check_rsp("R7 mixed", 4'b0111, 4'b0001, 3'd3);
        check_val("R7 lowest leader", 32'(refill_req_vpn), 32'h22222);

        // vector table: R2 R3 R4 R5 R6
        do_reset();
        do_refill(20'hdeadb, pfn_of(20'hdeadb));
        do_refill(20'h12345, pfn_of(20'h12345));
        do_refill(20'h00001, pfn_of(20'h00001));
        do_refill(20'h7ffff, pfn_of(20'h7ffff));
        for (int n = 0; n < 7; n++) begin
            logic [VW-1:0] e;
            e = VEC[n];
            do_lookup(e[138:135], e[134:103], e[102:71], e[70:39], e[38:7]);
            check_rsp($sformatf("R2 R3 R4 R5 R6 vec%0d", n), e[138:135], e[6:3], e[2:0]);
        end

        // R8 round robin: 33rd page evicts the first
        do_reset();
        for (int p = 0; p < 32; p++) do_refill(20'h00100 + 20'(p), pfn_of(20'h00100 + 20'(p)));
        do_refill(20'h00200, pfn_of(20'h00200));
        do_lookup(4'b1111, 32'h00100000, 32'h00101000, 32'h00200000, 32'h0011f000);
        check_rsp("R8 eviction", 4'b1111, 4'b1110, 3'd4);

        // R9 in-place update without pointer advance
        do_reset();
        do_refill(20'h00500, 20'h11111);
        do_refill(20'h00500, pfn_of(20'h00500));
        for (int p = 0; p < 31; p++) do_refill(20'h00600 + 20'(p), pfn_of(20'h00600 + 20'(p)));
        do_lookup(4'b0011, 32'h00500000, 32'h0061e000, 0, 0);
        check_rsp("R9 update kept", 4'b0011, 4'b0011, 3'd2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule